// File: doc/BRIEF.md
# FSK and DTMF Tone Synthesizer

This block is the digital transmit tone source of a low-speed line modem. It runs from a 3.579545 MHz master clock and divides that clock to a fixed sample rate. On every sample tick it produces one signed sample. A 3-bit mode input selects the job. The jobs are keyed FSK for the 300-baud and 1200-baud channels, the sixteen two-tone keypad signals, any one of the eight keypad frequencies alone, a steady 2100 Hz answer tone, or silence. A channel bit and a data bit select the carrier within an FSK mode.

Two identical voices carry the tones. Each voice has a phase accumulator feeding a quarter-wave sine table. A single-tone job uses the first voice only. The keypad job adds the second voice. After the two voices are summed, a 16-step gain table attenuates the result in 1 dB steps, and the product is registered onto the sample output. The DAC, the reconstruction filter and the line driver follow this block and are outside it.

Top module: `fsk_dtmf_tone_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `sample_o` is 0 after that edge, both phases are cleared, and the registered mode becomes idle (0).
- R2: A sample tick occurs on every `SAMPLE_DIV`-th clock, the first one on clock `SAMPLE_DIV` after reset release. On a tick, each phase grows by its step modulo 2^`PHASE_W`. Between ticks the phases do not change.
- R3: A tone of f Hz has the step round(f · 2^`PHASE_W` · `SAMPLE_DIV` / `CLK_HZ`), with half rounded up. With the default parameters every tone is within 1% of nominal.
- R4: Mode 1 is the 300-baud FSK mode. With `chan_i`=0 it sends 980 Hz when `txd_i`=1 and 1180 Hz when `txd_i`=0. With `chan_i`=1 it sends 1650 Hz when `txd_i`=1 and 1850 Hz when `txd_i`=0.
- R5: Mode 2 is the 1200-baud FSK mode. It sends 1300 Hz when `txd_i`=1 and 2100 Hz when `txd_i`=0, whatever the value of `chan_i`.
- R6: Mode 5 sends a steady 2100 Hz tone and ignores `txd_i`, `chan_i` and `code_i`.
- R7: Mode 3 sums a row tone and a column tone selected by `code_i`. The rows are 697/770/852/941 Hz and the columns are 1209/1336/1477/1633 Hz. Codes 1..9 map to keys 1..9, 10 to key 0, 11 to `*`, 12 to `#`, 13..15 to A..C, and 0 to D (941+1633).
- R8: Mode 4 sends one keypad frequency alone. `code_i[2]`=0 selects row `code_i[1:0]` and `code_i[2]`=1 selects column `code_i[1:0]`. `code_i[3]` is ignored.
- R9: A phase is converted to a tone value as follows. The top two bits are the quadrant q. The next `LUT_BITS` bits are the index i, which is mirrored to 2^`LUT_BITS`-1-i when q is odd. The magnitude is round((2^(`SAMPLE_W`-2)-1) · sin((i+0.5)·π/2^(`LUT_BITS`+1))). The value is negated when q ≥ 2.
- R10: The summed tone value s is scaled as floor(s·g/2^15), where g = min(32767, round(32768·10^(-k/20))) and k = `atten_i` (0..15 dB). The output never reaches the most negative code.
- R11: When `mode_i` differs from the mode registered on the previous clock, both phases are cleared at that edge instead of advancing. A change of `txd_i` or `code_i` leaves the phase running without a jump.
- R12: Mode 0 and the unused codes 6 and 7 give `sample_o` = 0.
- R13: `sample_o` is registered. After each edge it holds the result computed from the phases and inputs as they stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (3.579545 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Job select: 0 idle, 1 FSK 300 baud, 2 FSK 1200 baud, 3 keypad pair, 4 single keypad tone, 5 answer tone |
| chan_i | input | 1 | FSK 300-baud channel: 0 originate pair, 1 answer pair |
| txd_i | input | 1 | FSK data bit: 1 mark, 0 space |
| code_i | input | 4 | Keypad code for modes 3 and 4 |
| atten_i | input | 4 | Attenuation in dB, 0..15 |
| sample_o | output | SAMPLE_W | Signed output sample |

## Verification
A phase accumulator that is off by one step, or that advances on the wrong clock, shows at the output as a sample value that differs from an ideal sine track. Within one sample period after the fault the output no longer matches an independent model of the phases. A wrong frequency-select decode or a wrong gain entry gives a wrong output value on the very next registered sample. A missed phase clear on a mode switch shows on the first tick after the switch. The bench therefore compares the output with a behavioural model of the phases on every clock, across every mode, every key code and every attenuation step.

// File: rtl/tone_gen_pkg.sv
// Package: shared mode encoding, tone frequency list and constant helpers
// for the tone synthesizer. All functions are used at elaboration time.
package tone_gen_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE   = 3'd0,
        MODE_FSK300 = 3'd1,
        MODE_FSK1K2 = 3'd2,
        MODE_KEYPAD = 3'd3,
        MODE_SINGLE = 3'd4,
        MODE_ANSWER = 3'd5
    } tone_mode_e;

    localparam real PI_R = 3.14159265358979323846;

    // Index 0..3 keypad rows, 4..7 keypad columns, then the FSK carriers.
    localparam int NUM_TONES = 14;
    localparam int TONE_HZ [NUM_TONES] = '{697, 770, 852, 941,
                                           1209, 1336, 1477, 1633,
                                           980, 1180, 1650, 1850,
                                           1300, 2100};
    localparam int IX_ORG_MARK  = 8;
    localparam int IX_ORG_SPACE = 9;
    localparam int IX_ANS_MARK  = 10;
    localparam int IX_ANS_SPACE = 11;
    localparam int IX_HI_MARK   = 12;
    localparam int IX_HI_SPACE  = 13;
    localparam int IX_ANSWER    = 13;

    // Phase step for a tone: round(f * 2^pw * div / clk).
    function automatic longint phase_step(longint f_hz, longint clk_hz,
                                          longint div, int pw);
        return ((f_hz << pw) * div + clk_hz / 2) / clk_hz;
    endfunction

    // Keypad code to row number (0..3).
    function automatic logic [1:0] key_row(logic [3:0] code);
        case (code)
            4'd1, 4'd2, 4'd3, 4'd13:  return 2'd0;
            4'd4, 4'd5, 4'd6, 4'd14:  return 2'd1;
            4'd7, 4'd8, 4'd9, 4'd15:  return 2'd2;
            default:                  return 2'd3;
        endcase
    endfunction

    // Keypad code to column number (0..3).
    function automatic logic [1:0] key_col(logic [3:0] code);
        case (code)
            4'd1, 4'd4, 4'd7, 4'd11:  return 2'd0;
            4'd2, 4'd5, 4'd8, 4'd10:  return 2'd1;
            4'd3, 4'd6, 4'd9, 4'd12:  return 2'd2;
            default:                  return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/tone_freq_sel.sv
// Frequency selector: decodes mode, channel, data bit and keypad code
// into the phase steps of the two voices and their enables.
// Assumes the step table fits PHASE_W bits (tones below half the sample rate).
module tone_freq_sel
    import tone_gen_pkg::*;
#(
    parameter int CLK_HZ     = 3579545,
    parameter int SAMPLE_DIV = 448,
    parameter int PHASE_W    = 24
) (
    input  logic [2:0]         mode_i,
    input  logic               chan_i,
    input  logic               txd_i,
    input  logic [3:0]         code_i,
    output logic [PHASE_W-1:0] step_a_o,
    output logic [PHASE_W-1:0] step_b_o,
    output logic               use_a_o,
    output logic               use_b_o
);

    localparam int ROM_N = 2 ** $clog2(NUM_TONES);
    localparam int SEL_W = $clog2(ROM_N);

    logic [PHASE_W-1:0] step_rom [ROM_N];
    logic [SEL_W-1:0]   sel_a;
    logic [SEL_W-1:0]   sel_b;

    // Step table computed from the frequency list; padding entries are zero.
    for (genvar g = 0; g < ROM_N; g++) begin : g_step
        if (g < NUM_TONES) begin : g_tone
            localparam longint STEP = phase_step(longint'(TONE_HZ[g]),
                                                 longint'(CLK_HZ),
                                                 longint'(SAMPLE_DIV), PHASE_W);
            assign step_rom[g] = STEP[PHASE_W-1:0];
        end else begin : g_pad
            assign step_rom[g] = '0;
        end
    end

    // Pick the tone index of each voice from the requested job.
    always_comb begin
        sel_a   = '0;
        sel_b   = '0;
        use_a_o = 1'b0;
        use_b_o = 1'b0;
        case (tone_mode_e'(mode_i))
            MODE_FSK300: begin
                use_a_o = 1'b1;
                if (chan_i) sel_a = SEL_W'(txd_i ? IX_ANS_MARK : IX_ANS_SPACE);
                else        sel_a = SEL_W'(txd_i ? IX_ORG_MARK : IX_ORG_SPACE);
            end
            MODE_FSK1K2: begin
                use_a_o = 1'b1;
                sel_a   = SEL_W'(txd_i ? IX_HI_MARK : IX_HI_SPACE);
            end
            MODE_ANSWER: begin
                use_a_o = 1'b1;
                sel_a   = SEL_W'(IX_ANSWER);
            end
            MODE_KEYPAD: begin
                use_a_o = 1'b1;
                use_b_o = 1'b1;
                sel_a   = SEL_W'(key_row(code_i));
                sel_b   = SEL_W'(4 + int'(key_col(code_i)));
            end
            MODE_SINGLE: begin
                use_a_o = 1'b1;
                sel_a   = SEL_W'(code_i[2:0]);
            end
            default: ;
        endcase
    end

    assign step_a_o = use_a_o ? step_rom[sel_a] : '0;
    assign step_b_o = use_b_o ? step_rom[sel_b] : '0;

endmodule

// File: rtl/tone_phase_acc.sv
// Phase accumulator of one voice: clears on request, otherwise adds its
// step on each sample tick and wraps modulo 2^PHASE_W.
module tone_phase_acc #(
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               adv_i,
    input  logic [PHASE_W-1:0] step_i,
    output logic [PHASE_W-1:0] phase_o
);

    // Clear has priority over the tick advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) phase_o <= '0;
        else if (adv_i)      phase_o <= phase_o + step_i;
    end

endmodule

// File: rtl/tone_sine_lut.sv
// Quarter-wave sine lookup: maps a phase to a signed tone value whose peak
// is 2^(SAMPLE_W-2)-1, so two voices can be summed without overflow.
// The table is sampled at half-index offsets, making the mirror exact.
module tone_sine_lut
    import tone_gen_pkg::*;
#(
    parameter int PHASE_W  = 24,
    parameter int LUT_BITS = 6,
    parameter int SAMPLE_W = 16
) (
    input  logic [PHASE_W-1:0]         phase_i,
    output logic signed [SAMPLE_W-1:0] tone_o
);

    localparam int N     = 2 ** LUT_BITS;
    localparam int AMP   = 2 ** (SAMPLE_W - 2) - 1;
    localparam int MAG_W = SAMPLE_W - 1;

    logic [MAG_W-1:0]    quarter [N];
    logic [1:0]          quad;
    logic [LUT_BITS-1:0] idx_raw;
    logic [LUT_BITS-1:0] idx;
    logic [MAG_W-1:0]    mag;

    // Quarter-wave magnitudes computed at elaboration.
    for (genvar g = 0; g < N; g++) begin : g_quarter
        localparam real ANG = (real'(g) + 0.5) * PI_R / (2.0 * real'(N));
        localparam int  MAG = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
        assign quarter[g] = MAG_W'(MAG);
    end

    assign quad    = phase_i[PHASE_W-1 -: 2];
    assign idx_raw = LUT_BITS'(phase_i >> (PHASE_W - 2 - LUT_BITS));
    assign idx     = quad[0] ? ~idx_raw : idx_raw;
    assign mag     = quarter[idx];
    assign tone_o  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

endmodule

// File: rtl/tone_atten.sv
// Output stage: sums the enabled voices, applies the 1 dB-step gain
// (Q1.15, floor of the product) and registers the sample.
// Assumes each voice peaks at 2^(SAMPLE_W-2)-1.
module tone_atten #(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] tone_a_i,
    input  logic signed [SAMPLE_W-1:0] tone_b_i,
    input  logic                       use_a_i,
    input  logic                       use_b_i,
    input  logic [3:0]                 atten_i,
    output logic signed [SAMPLE_W-1:0] sample_o
);

    localparam int GAIN_N = 16;
    localparam int PROD_W = SAMPLE_W + 15;

    logic signed [15:0]         gain_rom [GAIN_N];
    logic signed [SAMPLE_W-1:0] part_a;
    logic signed [SAMPLE_W-1:0] part_b;
    logic signed [SAMPLE_W-1:0] sum;
    logic signed [PROD_W-1:0]   prod;

    // Gain per dB step, rounded and held below unity.
    for (genvar g = 0; g < GAIN_N; g++) begin : g_gain
        localparam real GR = 32768.0 * (10.0 ** (-real'(g) / 20.0));
        localparam int  GI = $rtoi(GR + 0.5);
        localparam int  GS = (GI > 32767) ? 32767 : GI;
        assign gain_rom[g] = 16'(GS);
    end

    assign part_a = use_a_i ? tone_a_i : '0;
    assign part_b = use_b_i ? tone_b_i : '0;
    assign sum    = part_a + part_b;
    assign prod   = PROD_W'(sum) * PROD_W'(gain_rom[atten_i]);

    // Register the scaled sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_o <= '0;
        else        sample_o <= SAMPLE_W'(prod >>> 15);
    end

endmodule

// File: rtl/fsk_dtmf_tone_gen.sv
// Top of the tone synthesizer: sample-rate divider, mode register that
// restarts the phases on a job change, two voices built by generate, and
// the attenuating output stage. Inputs are assumed synchronous to clk.
module fsk_dtmf_tone_gen
    import tone_gen_pkg::*;
#(
    parameter int CLK_HZ     = 3579545,
    parameter int SAMPLE_DIV = 448,
    parameter int PHASE_W    = 24,
    parameter int LUT_BITS   = 6,
    parameter int SAMPLE_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 mode_i,
    input  logic                       chan_i,
    input  logic                       txd_i,
    input  logic [3:0]                 code_i,
    input  logic [3:0]                 atten_i,
    output logic signed [SAMPLE_W-1:0] sample_o
);

    localparam int CNT_W   = $clog2(SAMPLE_DIV);
    localparam int NVOICES = 2;

    logic [CNT_W-1:0]           cnt_q;
    logic                       tick;
    logic [2:0]                 mode_q;
    logic                       mode_change;
    logic [PHASE_W-1:0]         step_v  [NVOICES];
    logic                       use_v   [NVOICES];
    logic [PHASE_W-1:0]         phase_v [NVOICES];
    logic signed [SAMPLE_W-1:0] tone_v  [NVOICES];

    assign tick        = (cnt_q == CNT_W'(SAMPLE_DIV - 1));
    assign mode_change = (mode_i != mode_q);

    // Sample-rate divider: one tick every SAMPLE_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // Remember the previous job to detect a switch.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_i;
    end

    tone_freq_sel #(
        .CLK_HZ     (CLK_HZ),
        .SAMPLE_DIV (SAMPLE_DIV),
        .PHASE_W    (PHASE_W)
    ) u_sel (
        .mode_i   (mode_i),
        .chan_i   (chan_i),
        .txd_i    (txd_i),
        .code_i   (code_i),
        .step_a_o (step_v[0]),
        .step_b_o (step_v[1]),
        .use_a_o  (use_v[0]),
        .use_b_o  (use_v[1])
    );

    for (genvar v = 0; v < NVOICES; v++) begin : g_voice
        tone_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (mode_change),
            .adv_i   (tick),
            .step_i  (step_v[v]),
            .phase_o (phase_v[v])
        );
        tone_sine_lut #(
            .PHASE_W  (PHASE_W),
            .LUT_BITS (LUT_BITS),
            .SAMPLE_W (SAMPLE_W)
        ) u_lut (
            .phase_i (phase_v[v]),
            .tone_o  (tone_v[v])
        );
    end

    tone_atten #(.SAMPLE_W(SAMPLE_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tone_a_i (tone_v[0]),
        .tone_b_i (tone_v[1]),
        .use_a_i  (use_v[0]),
        .use_b_i  (use_v[1]),
        .atten_i  (atten_i),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/fsk_dtmf_tone_gen_chk.sv
// Property checker for the tone synthesizer, bound to its top module.
module fsk_dtmf_tone_gen_chk #(
    parameter int PHASE_W  = 24,
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 mode_i,
    input logic [2:0]                 mode_q,
    input logic                       tick,
    input logic [PHASE_W-1:0]         phase_a,
    input logic [PHASE_W-1:0]         phase_b,
    input logic signed [SAMPLE_W-1:0] sample_o
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (sample_o == '0));

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && mode_i == mode_q) |=> ($stable(phase_a) && $stable(phase_b)));

    assert_no_min_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o != {1'b1, {(SAMPLE_W-1){1'b0}}});

    assert_restart_on_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |=> (phase_a == '0 && phase_b == '0));

    assert_idle_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 || mode_i == 3'd6 || mode_i == 3'd7) |=> (sample_o == '0));

endmodule

bind fsk_dtmf_tone_gen fsk_dtmf_tone_gen_chk #(
    .PHASE_W  (PHASE_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .mode_q   (mode_q),
    .tick     (tick),
    .phase_a  (phase_v[0]),
    .phase_b  (phase_v[1]),
    .sample_o (sample_o)
);

// File: tb/fsk_dtmf_tone_gen_tb_top.sv
// Bench: behavioural model of phases, tone values and gain, compared with
// the design output on every clock.
module fsk_dtmf_tone_gen_tb_top;

    localparam int  CLK_HZ = 3579545;
    localparam int  DIV    = 16;
    localparam int  PW     = 24;
    localparam int  LB     = 6;
    localparam int  SW     = 16;
    localparam int  AMP    = 2 ** (SW - 2) - 1;
    localparam int  NQ     = 2 ** LB;
    localparam longint PMASK = (64'd1 << PW) - 1;
    localparam real PI_R   = 3.14159265358979323846;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2:0]        mode;
    logic              chan;
    logic              txd;
    logic [3:0]        code;
    logic [3:0]        att;
    logic signed [SW-1:0] sample;

    int     n_checks = 0;
    int     n_fail   = 0;
    bit     cmp_en   = 1'b0;
    bit     done     = 1'b0;
    string  cur_tag  = "R1 reset";

    int     m_cnt;
    longint m_pa;
    longint m_pb;
    int     m_mode_q;
    int     m_out;

    always #2 clk = ~clk;

    fsk_dtmf_tone_gen #(
        .CLK_HZ     (CLK_HZ),
        .SAMPLE_DIV (DIV),
        .PHASE_W    (PW),
        .LUT_BITS   (LB),
        .SAMPLE_W   (SW)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .chan_i   (chan),
        .txd_i    (txd),
        .code_i   (code),
        .atten_i  (att),
        .sample_o (sample)
    );

    // Frequency in Hz of voice 0 or 1 for the given job (0 = voice off).
    function automatic int tone_hz(int m, bit ch, bit d, int c, bit second);
        string keys;
        byte   k;
        int    rows [4];
        int    cols [4];
        keys = "D1234567890*#ABC";
        k    = keys[c];
        rows = '{697, 770, 852, 941};
        cols = '{1209, 1336, 1477, 1633};
        case (m)
            1: return second ? 0 : (ch ? (d ? 1650 : 1850) : (d ? 980 : 1180));
            2: return second ? 0 : (d ? 1300 : 2100);
            5: return second ? 0 : 2100;
            4: return second ? 0 : (((c >> 2) & 1) != 0 ? cols[c & 3] : rows[c & 3]);
            3: begin
                if (!second) begin
                    if (k == "1" || k == "2" || k == "3" || k == "A") return 697;
                    if (k == "4" || k == "5" || k == "6" || k == "B") return 770;
                    if (k == "7" || k == "8" || k == "9" || k == "C") return 852;
                    return 941;
                end
                if (k == "1" || k == "4" || k == "7" || k == "*") return 1209;
                if (k == "2" || k == "5" || k == "8" || k == "0") return 1336;
                if (k == "3" || k == "6" || k == "9" || k == "#") return 1477;
                return 1633;
            end
            default: return 0;
        endcase
    endfunction

    function automatic longint step_of(int f);
        return ((longint'(f) << PW) * DIV + CLK_HZ / 2) / CLK_HZ;
    endfunction

    function automatic int sine_at(longint ph);
        int q;
        int i;
        int v;
        q = int'((ph >> (PW - 2)) & 3);
        i = int'((ph >> (PW - 2 - LB)) & (NQ - 1));
        if ((q & 1) != 0) i = NQ - 1 - i;
        v = $rtoi(real'(AMP) * $sin((real'(i) + 0.5) * PI_R / (2.0 * NQ)) + 0.5);
        return (q >= 2) ? -v : v;
    endfunction

    function automatic int scale(int s, int k);
        int     g;
        longint p;
        g = $rtoi(32768.0 * (10.0 ** (-real'(k) / 20.0)) + 0.5);
        if (g > 32767) g = 32767;
        p = longint'(s) * g;
        return int'(p >>> 15);
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        int fa;
        int fb;
        int s;
        if (!rst_n) begin
            m_cnt = 0; m_pa = 0; m_pb = 0; m_mode_q = 0; m_out = 0;
        end else begin
            fa = tone_hz(int'(mode), chan, txd, int'(code), 1'b0);
            fb = tone_hz(int'(mode), chan, txd, int'(code), 1'b1);
            s  = 0;
            if (fa != 0) s += sine_at(m_pa);
            if (fb != 0) s += sine_at(m_pb);
            m_out = scale(s, int'(att));
            if (int'(mode) != m_mode_q) begin
                m_pa = 0; m_pb = 0;
            end else if (m_cnt == DIV - 1) begin
                m_pa = (m_pa + step_of(fa)) & PMASK;
                m_pb = (m_pb + step_of(fb)) & PMASK;
            end
            m_cnt    = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            m_mode_q = int'(mode);
        end
    end

    task automatic check_val(input int act, input bit unk, input int exp, input string tag);
        n_checks++;
        if (unk || act != exp) begin
            n_fail++;
            $display("FAIL %s (R2 R9 R13): sample actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) check_val(int'(sample), $isunknown(sample), m_out, cur_tag);
    end

    task automatic apply(input int m, input bit ch, input bit d, input int c,
                         input int a, input int n, input string tag);
        @(negedge clk);
        mode = 3'(m); chan = ch; txd = d; code = 4'(c); att = 4'(a);
        cur_tag = tag;
        repeat (n) @(negedge clk);
    endtask

    task automatic fsk_run(input int m, input bit ch, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) begin
                mode = 3'(m); chan = ch; cur_tag = tag;
            end
            if (i % 37 == 0) txd = ~txd;
        end
    endtask

    initial begin
        rst_n = 1'b0; mode = '0; chan = 1'b0; txd = 1'b0; code = '0; att = '0;
        repeat (2) @(negedge clk);
        cmp_en = 1'b1;
        repeat (4) @(negedge clk);
        check_val(int'(sample), $isunknown(sample), 0, "R1 reset output");
        rst_n = 1'b1;

        apply(0, 1'b0, 1'b1, 5, 0, 200, "R12 idle");
        // R3 R4: 300-baud channels with data toggling, no phase jump (R11)
        fsk_run(1, 1'b0, 2500, "R4 R3 R11 fsk300 originate");
        fsk_run(1, 1'b1, 2500, "R4 R3 R11 fsk300 answer");
        fsk_run(2, 1'b0, 2000, "R5 fsk1200 chan0");
        fsk_run(2, 1'b1, 2000, "R5 fsk1200 chan1 ignored");
        apply(5, 1'b1, 1'b0, 9, 0, 1500, "R6 answer tone");
        apply(5, 1'b0, 1'b1, 3, 0, 1500, "R6 answer tone inputs ignored");
        for (int c = 0; c < 16; c++) apply(3, 1'b0, 1'b0, c, 0, 600, "R7 keypad pair");
        for (int c = 0; c < 16; c++) apply(4, 1'b0, 1'b0, c, 0, 400, "R8 single tone");
        for (int a = 0; a < 16; a++) apply(3, 1'b0, 1'b0, 5, a, 500, "R10 attenuation");
        apply(4, 1'b0, 1'b0, 7, 15, 300, "R10 single at 15 dB");
        apply(2, 1'b0, 1'b1, 0, 0, 45, "R11 restart before switch");
        apply(3, 1'b0, 1'b0, 0, 2, 77, "R11 switch to keypad");
        apply(1, 1'b1, 1'b0, 0, 0, 500, "R11 switch to fsk300");
        apply(6, 1'b0, 1'b1, 4, 0, 300, "R12 unused mode 6");
        apply(7, 1'b1, 1'b1, 8, 0, 300, "R12 unused mode 7");
        apply(3, 1'b0, 1'b0, 13, 0, 400, "R7 keypad after idle");

        cmp_en = 1'b0;
        done   = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #760000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule